// File: doc/BRIEF.md
# Trimmable Nanosecond Time-of-Day Counter

This block keeps a free-running time-of-day count for precision time protocol hardware. The visible count is a 40-bit binary number of nanoseconds. Below it sits a 32-bit fraction of a nanosecond. On every pulse of the reference tick input the count moves forward by a fixed nominal step of 8 ns. A signed fractional correction is also applied on each tick, so software can speed the clock up or slow it down in very fine steps without ever changing the nominal step.

Software reaches the block through a small 32-bit register port with four word addresses. Reading the low time word also captures the upper time bits in the same cycle, so a following read of the high word gives a value consistent with the low word. Writing the time is also split across two words: the low word is parked, and the full 40-bit value is loaded when the high word is written. A halt bit stops the counter. Reset sets the halt bit, so software must clear it to start counting.

The correction word uses sign-magnitude form. Its top bit selects subtraction, and its lower 31 bits give the step size in units of 2^-32 ns. A correction of p parts per billion maps to p·2^26/1953125 of these units. The largest supported correction is 62,499,999 ppb.

Top module: `tod_frac_counter`

## Requirements
- R1: After reset the time count, the fraction and the correction word are zero and the counter is halted. Reading the control word (address 3) returns 0x8000_0000, and reading the correction word (address 2) returns 0.
- R2: While bit 31 of the control word is 1, ticks do not change the time. Writing 0 to the control word lets counting start from the next tick.
- R3: With a zero correction, each tick adds exactly 8 ns. A cycle without a tick leaves the time unchanged.
- R4: With correction bit 31 clear, the magnitude in bits 30:0 is added to the 32-bit fraction on each tick. A carry out of the fraction adds one extra nanosecond on that same tick (0x4000_0000 gives 8, 16, 24, 33 ns over four ticks).
- R5: With correction bit 31 set, the magnitude is subtracted from the fraction on each tick. A borrow removes one nanosecond on that same tick (0xC000_0000 from zero fraction gives 7, 15, 23, 31 ns).
- R6: The time count wraps modulo 2^40.
- R7: Reading address 0 returns time bits 31:0 and captures bits 39:32. A later read of address 1 returns the captured bits in bits 7:0, with zeros in bits 31:8, even if the live count has moved on.
- R8: A write to address 0 is held and does not change the time. A write to address 1 loads the time with bits 7:0 of that write above the held low word, ignores the upper bits of that write, and clears the fraction.
- R9: When a tick arrives in the same cycle as a write to address 1, the load wins and that tick is dropped.
- R10: Read data and the read-valid flag appear in the cycle after a read request.
- R11: The correction word (address 2) reads back the value last written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Reference tick; one pulse advances the time once |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Word select: 0 time low, 1 time high, 2 correction, 3 control |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| rd_valid | output | 1 | Marks reg_rdata as valid for the read of the previous cycle |
| time_ns | output | 40 | Live nanosecond count |

## Verification
A tick or a loading write changes time_ns at the first rising edge where it is sampled, so the result is due one cycle after the stimulus. A read returns reg_rdata and rd_valid one cycle after the request. A high-word read placed right after a low-word read shows the bits captured two cycles earlier. The bench drives every input on a falling edge and samples at the next falling edge, half a period after the edge that carries the result. In this way each check falls exactly on the cycle in which its result is due.

// File: rtl/tod_pkg.sv
package tod_pkg;
  // Word select on the register port
  typedef enum logic [1:0] {
    SEL_TLO  = 2'd0,
    SEL_THI  = 2'd1,
    SEL_TRIM = 2'd2,
    SEL_CTRL = 2'd3
  } tod_sel_e;
endpackage

// File: rtl/tod_regfile.sv
module tod_regfile
  import tod_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NS_W   = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] trim_word,
  output logic              halt,
  output logic              load_en,
  output logic [NS_W-1:0]   load_val
);
  localparam int HI_W = NS_W - DATA_W;

  tod_sel_e          sel;
  logic [DATA_W-1:0] lo_hold;

  assign sel      = tod_sel_e'(reg_addr);
  assign load_en  = reg_wr && (sel == SEL_THI);
  assign load_val = {reg_wdata[HI_W-1:0], lo_hold};

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_hold   <= '0;
      trim_word <= '0;
      halt      <= 1'b1;
    end else if (reg_wr) begin
      case (sel)
        SEL_TLO:  lo_hold   <= reg_wdata;
        SEL_TRIM: trim_word <= reg_wdata;
        SEL_CTRL: halt      <= reg_wdata[DATA_W-1];
        default:  ;
      endcase
    end
  end

  // R2: a control write sets the halt state to the written top bit
  assert_ctrl_halt_R2: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && sel == SEL_CTRL) |=> (halt == $past(reg_wdata[DATA_W-1])));
endmodule

// File: rtl/tod_core.sv
module tod_core #(
  parameter int NS_W    = 40,
  parameter int FRAC_W  = 32,
  parameter int DATA_W  = 32,
  parameter int STEP_NS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              halt,
  input  logic [DATA_W-1:0] trim_word,
  input  logic              load_en,
  input  logic [NS_W-1:0]   load_val,
  output logic [NS_W-1:0]   ns_q
);
  localparam int MAG_W = DATA_W - 1;
  localparam int PAD_W = FRAC_W + 1 - MAG_W;
  localparam logic [NS_W-1:0] STEP_NOM = NS_W'(STEP_NS);
  localparam logic [NS_W-1:0] STEP_UP  = NS_W'(STEP_NS + 1);
  localparam logic [NS_W-1:0] STEP_DN  = NS_W'(STEP_NS - 1);

  logic [NS_W-1:0]   ns_r;
  logic [FRAC_W-1:0] frac_r;
  logic [FRAC_W:0]   mag_ext;
  logic [FRAC_W:0]   frac_sum;
  logic              trim_neg;
  logic              frac_cy;
  logic [NS_W-1:0]   ns_step;
  logic              advance;

  assign trim_neg = trim_word[DATA_W-1];
  assign mag_ext  = {{PAD_W{1'b0}}, trim_word[MAG_W-1:0]};
  assign advance  = tick && !halt && !load_en;

  always_comb begin
    if (trim_neg) frac_sum = {1'b0, frac_r} - mag_ext;
    else          frac_sum = {1'b0, frac_r} + mag_ext;
    frac_cy = frac_sum[FRAC_W];
    if (!frac_cy)      ns_step = STEP_NOM;
    else if (trim_neg) ns_step = STEP_DN;
    else               ns_step = STEP_UP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ns_r   <= '0;
      frac_r <= '0;
    end else if (load_en) begin
      ns_r   <= load_val;
      frac_r <= '0;
    end else if (advance) begin
      ns_r   <= ns_r + ns_step;
      frac_r <= frac_sum[FRAC_W-1:0];
    end
  end

  assign ns_q = ns_r;

  // R2: halted and not loading, the count holds
  assert_halt_freeze_R2: assert property (@(posedge clk) disable iff (rst)
    (halt && !load_en) |=> $stable(ns_r));

  // R3: without tick or load, the count holds
  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load_en) |=> $stable(ns_r));

  // R3: a counted tick moves the time by one step, give or take one
  assert_step_bound_R3: assert property (@(posedge clk) disable iff (rst)
    advance |=> ((ns_r - $past(ns_r)) == STEP_NOM ||
                 (ns_r - $past(ns_r)) == STEP_UP  ||
                 (ns_r - $past(ns_r)) == STEP_DN));

  // R4: a positive correction never shortens a step
  assert_pos_no_short_R4: assert property (@(posedge clk) disable iff (rst)
    (advance && !trim_neg) |=> ((ns_r - $past(ns_r)) != STEP_DN));

  // R5: a negative correction never lengthens a step
  assert_neg_no_long_R5: assert property (@(posedge clk) disable iff (rst)
    (advance && trim_neg) |=> ((ns_r - $past(ns_r)) != STEP_UP));

  // R8 and R9: a load lands exactly, whatever the tick did
  assert_load_exact_R9: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (ns_r == $past(load_val)));
endmodule

// File: rtl/tod_rdport.sv
module tod_rdport
  import tod_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NS_W   = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [NS_W-1:0]   ns_q,
  input  logic [DATA_W-1:0] trim_word,
  input  logic              halt,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              rd_valid
);
  localparam int HI_W  = NS_W - DATA_W;
  localparam int PAD_W = DATA_W - HI_W;

  tod_sel_e        sel;
  logic [HI_W-1:0] snap_hi;

  assign sel = tod_sel_e'(reg_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      rd_valid  <= 1'b0;
      snap_hi   <= '0;
    end else begin
      rd_valid <= reg_rd;
      if (reg_rd) begin
        case (sel)
          SEL_TLO: begin
            reg_rdata <= ns_q[DATA_W-1:0];
            snap_hi   <= ns_q[NS_W-1:DATA_W];
          end
          SEL_THI:  reg_rdata <= {{PAD_W{1'b0}}, snap_hi};
          SEL_TRIM: reg_rdata <= trim_word;
          SEL_CTRL: reg_rdata <= {halt, {(DATA_W-1){1'b0}}};
          default:  ;
        endcase
      end
    end
  end

  // R10: valid follows a request by one cycle
  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> rd_valid);
  assert_valid_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> !rd_valid);

  // R7: reserved high bits read as zero
  assert_hi_reserved_R7: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && sel == SEL_THI) |=> (reg_rdata[DATA_W-1:HI_W] == '0));

  // R7: a high read right after a low read shows the time of the low read
  assert_snap_coherent_R7: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && sel == SEL_THI && $past(reg_rd && sel == SEL_TLO))
      |=> (reg_rdata[HI_W-1:0] == $past(ns_q[NS_W-1:DATA_W], 2)));
endmodule

// File: rtl/tod_frac_counter.sv
module tod_frac_counter #(
  parameter int NS_W    = 40,
  parameter int FRAC_W  = 32,
  parameter int DATA_W  = 32,
  parameter int STEP_NS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              rd_valid,
  output logic [NS_W-1:0]   time_ns
);
  logic [DATA_W-1:0] trim_word;
  logic              halt;
  logic              load_en;
  logic [NS_W-1:0]   load_val;
  logic [NS_W-1:0]   ns_q;

  tod_regfile #(.DATA_W(DATA_W), .NS_W(NS_W)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .trim_word(trim_word), .halt(halt),
    .load_en(load_en), .load_val(load_val)
  );

  tod_core #(.NS_W(NS_W), .FRAC_W(FRAC_W), .DATA_W(DATA_W), .STEP_NS(STEP_NS)) u_core (
    .clk(clk), .rst(rst), .tick(tick), .halt(halt), .trim_word(trim_word),
    .load_en(load_en), .load_val(load_val), .ns_q(ns_q)
  );

  tod_rdport #(.DATA_W(DATA_W), .NS_W(NS_W)) u_rd (
    .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_addr(reg_addr), .ns_q(ns_q),
    .trim_word(trim_word), .halt(halt), .reg_rdata(reg_rdata), .rd_valid(rd_valid)
  );

  assign time_ns = ns_q;
endmodule

// File: tb/test_tod_frac_counter.sv
module test_tod_frac_counter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        rd_valid;
  logic [39:0] time_ns;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  localparam logic [1:0] A_LO = 2'd0, A_HI = 2'd1, A_TRIM = 2'd2, A_CTRL = 2'd3;

  tod_frac_counter i_tod_frac_counter (
    .clk(clk), .rst(rst), .tick(tick), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rd_valid(rd_valid), .time_ns(time_ns)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
    check("R10 valid", {63'd0, rd_valid}, 64'd1);
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic load(input logic [39:0] v);
    wr(A_LO, v[31:0]);
    wr(A_HI, {24'd0, v[39:32]});
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 time", {24'd0, time_ns}, 64'd0);
    check("R10 idle valid", {63'd0, rd_valid}, 64'd0);
    rd(A_CTRL, d); check("R1 ctrl", {32'd0, d}, 64'h8000_0000);
    rd(A_TRIM, d); check("R1 trim", {32'd0, d}, 64'd0);
    rd(A_LO, d);   check("R1 low", {32'd0, d}, 64'd0);
    ticks(5);      check("R2 halted", {24'd0, time_ns}, 64'd0);
  endtask

  task automatic t_nominal;
    wr(A_CTRL, 32'd0);
    ticks(10); check("R3 ten ticks", {24'd0, time_ns}, 64'd80);
    repeat (3) @(negedge clk);
    check("R3 no tick", {24'd0, time_ns}, 64'd80);
  endtask

  task automatic t_pos_trim;
    logic [31:0] d;
    wr(A_CTRL, 32'h8000_0000);
    load(40'd0);
    wr(A_TRIM, 32'h4000_0000);
    rd(A_TRIM, d); check("R11 trim back", {32'd0, d}, 64'h4000_0000);
    wr(A_CTRL, 32'd0);
    ticks(3); check("R4 three ticks", {24'd0, time_ns}, 64'd24);
    ticks(1); check("R4 carry tick", {24'd0, time_ns}, 64'd33);
  endtask

  task automatic t_neg_trim;
    logic [31:0] d;
    wr(A_CTRL, 32'h8000_0000);
    load(40'd1000);
    wr(A_TRIM, 32'hC000_0000);
    rd(A_TRIM, d); check("R11 neg trim back", {32'd0, d}, 64'hC000_0000);
    wr(A_CTRL, 32'd0);
    ticks(1); check("R5 borrow tick", {24'd0, time_ns}, 64'd1007);
    ticks(3); check("R5 four ticks", {24'd0, time_ns}, 64'd1031);
  endtask

  task automatic t_split_write;
    wr(A_CTRL, 32'h8000_0000);
    load(40'd55);
    wr(A_LO, 32'hDEAD_BEEF);
    check("R8 low held", {24'd0, time_ns}, 64'd55);
    wr(A_HI, 32'hFFFF_FFA5);
    check("R8 load", {24'd0, time_ns}, 64'hA5_DEAD_BEEF);
  endtask

  task automatic t_frac_clear;
    wr(A_CTRL, 32'h8000_0000);
    load(40'd0);
    wr(A_TRIM, 32'h4000_0000);
    wr(A_CTRL, 32'd0);
    ticks(3);
    load(40'h200);
    ticks(3); check("R8 fraction cleared", {24'd0, time_ns}, 64'h218);
  endtask

  task automatic t_wrap;
    wr(A_CTRL, 32'h8000_0000);
    wr(A_TRIM, 32'd0);
    load(40'hFF_FFFF_FFFC);
    wr(A_CTRL, 32'd0);
    ticks(1); check("R6 wrap", {24'd0, time_ns}, 64'd4);
  endtask

  task automatic t_snapshot;
    wr(A_CTRL, 32'h8000_0000);
    load(40'h12_FFFF_FFF0);
    wr(A_CTRL, 32'd0);
    @(negedge clk);
    tick = 1'b1; reg_rd = 1'b1; reg_addr = A_LO;
    @(negedge clk);
    check("R7 low word", {32'd0, reg_rdata}, 64'hFFFF_FFF0);
    reg_addr = A_HI;
    @(negedge clk);
    tick = 1'b0; reg_rd = 1'b0;
    check("R7 high snapshot", {32'd0, reg_rdata}, 64'h12);
    check("R7 live moved", {24'd0, time_ns}, 64'h13_0000_0000);
  endtask

  task automatic t_collide;
    wr(A_CTRL, 32'd0);
    wr(A_LO, 32'h100);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = A_HI; reg_wdata = 32'd0; tick = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    check("R9 tick dropped", {24'd0, time_ns}, 64'h100);
    @(negedge clk);
    tick = 1'b0;
    check("R9 next tick", {24'd0, time_ns}, 64'h108);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_nominal();
    t_pos_trim();
    t_neg_trim();
    t_split_write();
    t_frac_clear();
    t_wrap();
    t_snapshot();
    t_collide();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end
endmodule